// File: doc/BRIEF.md
# Gated-Feedback Multiply-Subtract Loop

This block holds a W-bit unsigned accumulator value `cOut`. On each clock where the update strobe is high, it replaces that value with `(opA + opB) * cOut - opD`, keeping only the low W bits. The stored value feeds back as the multiplier operand of the next evaluation. The recurrence is therefore advanced one step per enabled clock, and frozen otherwise. Without the gate, the loop would recompute on every cycle.

The arithmetic is built only from adders. The sum `opA + opB` is formed first. The multiply is an array of shifted partial products whose adders narrow by one bit per stage. The subtraction adds the two's complement of `opD`. A synchronous active-high reset seeds the loop from `initVal`. A registered valid flag marks the cycle that follows each step.

Top module: `mulsub_loop`

## Requirements
- R1: On a clock edge with `rst` high, `cOut` takes the value of `initVal` and `validOut` goes low.
- R2: On a clock edge with `rst` low and `updateEn` high, `cOut` becomes ((opA + opB) * cOut - opD) mod 2^W. The value of `cOut` used is the one before that edge. The operands are unsigned.
- R3: On a clock edge with `rst` low and `updateEn` low, `cOut` keeps its value, whatever `opA`, `opB`, `opD` and `initVal` do.
- R4: `validOut` is high in the cycle after each enabled update and low after any edge without one.
- R5: When `opD` exceeds the truncated product, the result wraps modulo 2^W; for example, 2 - 5 yields 2^W - 3.
- R6: When `rst` and `updateEn` are both high on the same edge, the reset wins: `cOut` equals `initVal` and `validOut` is low.
- R7: A carry out of `opA + opB` beyond W bits has no effect on the result.
- R8: Back-to-back enabled edges chain the recurrence, and each step uses the previous step's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, seeds the loop |
| updateEn | input | 1 | Step strobe for the recurrence |
| opA | input | W | First addend |
| opB | input | W | Second addend |
| opD | input | W | Subtrahend |
| initVal | input | W | Seed value loaded on reset |
| cOut | output | W | Current loop value |
| validOut | output | 1 | High for the cycle after an enabled step |

## Verification
Reset and the update strobe can both be asserted on the same edge. The bench drives exactly that pair with operands that would give a result different from the seed. It then expects the seed value and a low valid flag on the next cycle (R6). The scoreboard model applies reset before enable, so any ordering slip in the control shows up as a value mismatch. The random phase also draws both strobes independently, which produces further collisions.

// File: rtl/mulsub_pkg.sv
package mulsub_pkg;
  typedef struct packed {
    logic loadInit;
    logic loadNext;
  } loopStrobes_t;
endpackage

// File: rtl/mulsub_ctrl.sv
module mulsub_ctrl
  import mulsub_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         updateEn,
  output loopStrobes_t strobes,
  output logic         validOut
);
  always_comb begin
    strobes.loadInit = rst;
    strobes.loadNext = !rst && updateEn;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= updateEn;
  end
endmodule

// File: rtl/mulsub_dp.sv
module mulsub_dp
  import mulsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  loopStrobes_t strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opD,
  input  logic [W-1:0] initVal,
  output logic [W-1:0] cOut
);
  logic [W-1:0] cReg;
  logic [W:0]   sumAB;
  logic [W-1:0] mcand;
  logic [W-1:0] pp [W];
  logic [W-1:0] negD;
  logic [W-1:0] nextVal;

  // Full-width sum; only the low W bits reach a W-bit truncated product.
  assign sumAB = {1'b0, opA} + {1'b0, opB};
  assign mcand = sumAB[W-1:0];

  // Stage n adds mcand<<n; only bits W-1..n can change, so adder is W-n wide.
  for (genvar n = 0; n < W; n++) begin : gStage
    if (n == 0) begin : gFirst
      assign pp[0] = cReg[0] ? mcand : '0;
    end else begin : gNext
      logic [W-1-n:0] upper;
      assign upper = pp[n-1][W-1:n] + (cReg[n] ? mcand[W-1-n:0] : '0);
      assign pp[n] = {upper, pp[n-1][n-1:0]};
    end
  end

  assign negD    = ~opD + W'(1);
  assign nextVal = pp[W-1] + negD;

  always_ff @(posedge clk) begin
    if (strobes.loadInit)      cReg <= initVal;
    else if (strobes.loadNext) cReg <= nextVal;
  end

  assign cOut = cReg;
endmodule

// File: rtl/mulsub_loop.sv
module mulsub_loop
  import mulsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         updateEn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opD,
  input  logic [W-1:0] initVal,
  output logic [W-1:0] cOut,
  output logic         validOut
);
  loopStrobes_t strobes;

  mulsub_ctrl uCtrl (
    .clk(clk), .rst(rst), .updateEn(updateEn),
    .strobes(strobes), .validOut(validOut)
  );

  mulsub_dp #(.W(W)) uDp (
    .clk(clk), .strobes(strobes), .opA(opA), .opB(opB), .opD(opD),
    .initVal(initVal), .cOut(cOut)
  );
endmodule

// File: rtl/mulsub_chk.sv
module mulsub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         updateEn,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] opD,
  input logic [W-1:0] initVal,
  input logic [W-1:0] cOut,
  input logic         validOut
);
  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  function automatic logic [W-1:0] refStep(input logic [W-1:0] a, b, c, d);
    logic [2*W+1:0] wide;
    wide = ({{(W+2){1'b0}}, a} + {{(W+2){1'b0}}, b}) * {{(W+2){1'b0}}, c}
           - {{(W+2){1'b0}}, d};
    return wide[W-1:0];
  endfunction

  AST_RESET_SEED: assert property (@(posedge clk) disable iff (!pastValid)
    rst |=> (cOut == $past(initVal)) && !validOut); // R1

  AST_STEP_VALUE: assert property (@(posedge clk) disable iff (rst || !pastValid)
    updateEn |=> cOut == $past(refStep(opA, opB, cOut, opD))); // R2

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst || !pastValid)
    !updateEn |=> $stable(cOut)); // R3

  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst || !pastValid)
    updateEn |=> validOut); // R4

  AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst || !pastValid)
    !updateEn |=> !validOut); // R4

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!pastValid)
    (rst && updateEn) |=> (cOut == $past(initVal))); // R6
endmodule

bind mulsub_loop mulsub_chk #(.W(W)) uChk (
  .clk(clk), .rst(rst), .updateEn(updateEn), .opA(opA), .opB(opB),
  .opD(opD), .initVal(initVal), .cOut(cOut), .validOut(validOut)
);

// File: tb/tb_mulsub_loop.sv
module tb_mulsub_loop;
  localparam int W = 8;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst, updateEn;
  logic [W-1:0] opA, opB, opD, initVal;
  logic [W-1:0] cOut;
  logic validOut;

  always #10 clk = ~clk;

  mulsub_loop #(.W(W)) dut (
    .clk(clk), .rst(rst), .updateEn(updateEn), .opA(opA), .opB(opB),
    .opD(opD), .initVal(initVal), .cOut(cOut), .validOut(validOut)
  );

  typedef struct {
    logic [W-1:0] c;
    logic         v;
    string        tag;
  } expItem_t;

  expItem_t sbq[$];
  int checks = 0;
  int errors = 0;
  longint mC = 0;
  logic   mV = 1'b0;
  bit     done = 1'b0;

  // Driver: drives at negedge, advances the model, queues the expectation.
  task automatic step(input logic r, input logic en, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [W-1:0] d,
                      input logic [W-1:0] ini, input string tag);
    expItem_t it;
    @(negedge clk);
    rst = r; updateEn = en; opA = a; opB = b; opD = d; initVal = ini;
    if (r) begin
      mC = longint'(ini); mV = 1'b0;
    end else if (en) begin
      mC = ((longint'(a) + longint'(b)) * mC - longint'(d)) & MASK;
      mV = 1'b1;
    end else begin
      mV = 1'b0;
    end
    it.c = W'(mC); it.v = mV; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: samples mid-high phase after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        expItem_t e;
        e = sbq.pop_front();
        checks++;
        if (cOut !== e.c || validOut !== e.v) begin
          errors++;
          $display("FAIL %s: cOut=%0d validOut=%0b expected cOut=%0d validOut=%0b",
                   e.tag, cOut, validOut, e.c, e.v);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; updateEn = 1'b0; opA = '0; opB = '0; opD = '0; initVal = '0;
    step(1, 0, 0, 0, 0, 8'd3, "R1 reset seed");
    step(1, 0, 0, 0, 0, 8'd3, "R1 reset held");
    // R3: operands and seed wiggle without enable
    step(0, 0, 8'd9, 8'd7, 8'd1, 8'd99, "R3 hold");
    step(0, 0, 8'd255, 8'd1, 8'd4, 8'd12, "R3 hold changing ops");
    // R2: (2+3)*3-4 = 11
    step(0, 1, 8'd2, 8'd3, 8'd4, 8'd0, "R2 step");
    step(0, 0, 8'd2, 8'd3, 8'd4, 8'd0, "R4 valid drops");
    // R2 with zero subtrahend: (1+1)*11 = 22
    step(0, 1, 8'd1, 8'd1, 8'd0, 8'd0, "R2 zero d");
    // R5: seed 2, (1+0)*2-5 = -3 -> 253
    step(1, 0, 0, 0, 0, 8'd2, "R1 reseed");
    step(0, 1, 8'd1, 8'd0, 8'd5, 8'd0, "R5 wrap");
    // R7: (200+100)=300, low 8 bits 44; 44*253-0 mod 256
    step(0, 1, 8'd200, 8'd100, 8'd0, 8'd0, "R7 sum carry");
    // R8: chain of consecutive steps
    step(1, 0, 0, 0, 0, 8'd1, "R1 reseed chain");
    for (int i = 0; i < 6; i++)
      step(0, 1, 8'd1, 8'd2, 8'd1, 8'd0, "R8 chain");
    // R6: reset and enable collide
    step(1, 1, 8'd5, 8'd6, 8'd7, 8'd42, "R6 reset wins");
    step(0, 0, 8'd5, 8'd6, 8'd7, 8'd77, "R6 after collision hold");
    // Random mix of all strobes
    for (int i = 0; i < 300; i++)
      step(($urandom % 16) == 0, $urandom % 2,
           W'($urandom), W'($urandom), W'($urandom), W'($urandom),
           "R2 R3 R4 random");
    @(negedge clk);
    rst = 1'b0; updateEn = 1'b0;
    @(posedge clk);
    #7;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule